// File: doc/BRIEF.md
# Page-Swap Crossover Engine

This block performs recombination between two linear register-machine programs that live in a shared single-port instruction memory. Every program is made of whole pages, and all pages in the population have the same fixed length. The block chooses one page in each parent and exchanges the contents of those two pages, one word at a time. Because the two exchanged segments are always the same size, each offspring keeps the length of its parent. Nothing is moved, reallocated or resized.

A controller presents the base address and page count of each parent, together with a raw page-pick value for each parent, and pulses start. The pick values may come from a random source. The block reduces each pick to a page index that is valid for its parent and computes the start address of that page. It then runs the exchange through the memory port. At the end it raises done for one cycle. Fitness evaluation, parent selection and random number generation belong to neighbouring blocks.

The controller is a Moore state machine with seven states:
- IDLE: waits for start.
- CALC: resolves the page addresses.
- RDA: reads the word from the first parent's page.
- RDB: reads the word from the second parent's page.
- WRA: writes the first parent's slot.
- WRB: writes the second parent's slot.
- FIN: raises done.

Its transitions are:
- IDLE→CALC when start is seen.
- CALC→FIN when both pages share one address.
- CALC→RDA otherwise.
- RDA→RDB→WRA→WRB for each word.
- WRB→RDA when more words remain.
- WRB→FIN after the last word.
- FIN→IDLE.

Top module: `pgx_xover`

## Requirements
- R1: After reset, and whenever no exchange is running, busy_o, done_o, mem_en_o and mem_we_o are all 0.
- R2: The effective page count of a parent is its pages input, except that 0 counts as 1 and values above MAX_PAGES (16) count as 16. The selected page is pick mod effective count. The page start address is base + page*PAGE_LEN (PAGE_LEN = 8), wrapping modulo 2^ADDR_W.
- R3: When done is seen, the two selected pages hold each other's former contents and every other memory word is unchanged.
- R4: For word offsets k = 0 up to PAGE_LEN-1 in ascending order, the block uses four consecutive memory cycles. It reads page A word k, then reads page B word k, then writes page A word k, then writes page B word k.
- R5: Read data is taken from mem_rdata_i in the cycle directly after the read request. The write to page A carries the word just read from page B, and the write to page B carries the word read from page A.
- R6: Start is sampled only in IDLE. The cycle after an accepted start is an address-resolution cycle with busy_o = 1 and no memory access. busy_o stays high up to and including the done cycle.
- R7: done_o is high for exactly one cycle, the cycle after the last write, and the block is idle in the following cycle.
- R8: A start pulse while busy, including in the done cycle, is ignored. The running exchange and its operands are unaffected.
- R9: If both selected pages start at the same address, no memory access is made and done_o is raised in the second cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one crossover (sampled in IDLE only) |
| base_a_i | input | 10 | First address of parent A |
| pages_a_i | input | 5 | Page count of parent A |
| pick_a_i | input | 8 | Raw page pick for parent A |
| base_b_i | input | 10 | First address of parent B |
| pages_b_i | input | 5 | Page count of parent B |
| pick_b_i | input | 8 | Raw page pick for parent B |
| mem_en_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 10 | Memory word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the read |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the following corner cases:
- Picks far above the page count, and page counts of zero or above the maximum. A wrong reduction or clamp would send reads and writes to the wrong page.
- A page whose address wraps past the top of memory, and two partially overlapping pages. A design that buffered a whole page instead of swapping word by word would leave different contents in the overlap.
- Two picks that land on the same address. A design that swapped anyway would show memory traffic, and its done pulse would come about thirty cycles late.
- Start pulses raised mid-exchange and in the done cycle. A design that accepted them would restart the walk or change its operands.

// File: rtl/pgx_pkg.sv
`timescale 1ns/1ps
package pgx_pkg;

    // Controller states of the page-swap engine
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CALC = 3'd1,
        ST_RDA  = 3'd2,
        ST_RDB  = 3'd3,
        ST_WRA  = 3'd4,
        ST_WRB  = 3'd5,
        ST_FIN  = 3'd6
    } pgx_state_e;

endpackage

// File: rtl/pgx_page_loc.sv
`timescale 1ns/1ps
// Reduces a raw page pick to a valid page of one parent and returns the page's
// start address. The remainder is formed by an unrolled restoring divider.
module pgx_page_loc #(
    parameter int ADDR_W    = 10,
    parameter int PAGE_LEN  = 8,
    parameter int MAX_PAGES = 16,
    parameter int SEL_W     = 8,
    localparam int CNT_W    = $clog2(MAX_PAGES + 1),
    localparam int RW       = CNT_W + 1
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  pages_i,
    input  logic [SEL_W-1:0]  pick_i,
    output logic [RW-1:0]     div_o,
    output logic [RW-1:0]     idx_o,
    output logic [ADDR_W-1:0] addr_o
);

    // Effective page count: zero counts as one, oversize clamps to the maximum
    always_comb begin
        if (pages_i == '0)
            div_o = RW'(1);
        else if (pages_i > CNT_W'(MAX_PAGES))
            div_o = RW'(MAX_PAGES);
        else
            div_o = {1'b0, pages_i};
    end

    // Restoring remainder, one stage per pick bit, most significant bit first
    logic [RW-1:0] rem [0:SEL_W];
    assign rem[0] = '0;

    for (genvar i = 0; i < SEL_W; i++) begin : g_stage
        logic [RW:0] shifted;
        assign shifted  = {rem[i], pick_i[SEL_W-1-i]};
        assign rem[i+1] = (shifted >= {1'b0, div_o}) ? RW'(shifted - {1'b0, div_o})
                                                     : shifted[RW-1:0];
    end

    assign idx_o = rem[SEL_W];

    logic [ADDR_W-1:0] offset;
    assign offset = ADDR_W'(idx_o) * ADDR_W'(PAGE_LEN);
    assign addr_o = base_i + offset;

endmodule

// File: rtl/pgx_word_ctr.sv
`timescale 1ns/1ps
// Word offset within the page being exchanged.
module pgx_word_ctr #(
    parameter int PAGE_LEN = 8,
    localparam int WORD_W  = (PAGE_LEN > 1) ? $clog2(PAGE_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [WORD_W-1:0] word_o,
    output logic              last_o
);

    assign last_o = (word_o == WORD_W'(PAGE_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word_o <= '0;
        else if (clr_i)
            word_o <= '0;
        else if (inc_i)
            word_o <= last_o ? '0 : word_o + WORD_W'(1);
    end

endmodule

// File: rtl/pgx_xover.sv
`timescale 1ns/1ps
// Page-swap crossover engine: exchanges one fixed-length page between two
// programs held in a single-port instruction memory.
module pgx_xover #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 16,
    parameter int PAGE_LEN  = 8,
    parameter int MAX_PAGES = 16,
    parameter int SEL_W     = 8,
    localparam int CNT_W    = $clog2(MAX_PAGES + 1),
    localparam int RW       = CNT_W + 1,
    localparam int WORD_W   = (PAGE_LEN > 1) ? $clog2(PAGE_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_a_i,
    input  logic [CNT_W-1:0]  pages_a_i,
    input  logic [SEL_W-1:0]  pick_a_i,
    input  logic [ADDR_W-1:0] base_b_i,
    input  logic [CNT_W-1:0]  pages_b_i,
    input  logic [SEL_W-1:0]  pick_b_i,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o
);
    import pgx_pkg::*;

    pgx_state_e state_q, state_d;

    // Operands captured when a start is accepted
    logic [ADDR_W-1:0] base_a_q, base_b_q;
    logic [CNT_W-1:0]  pages_a_q, pages_b_q;
    logic [SEL_W-1:0]  pick_a_q, pick_b_q;

    // Resolved page starts and the word held between its read and its write
    logic [ADDR_W-1:0] addr_a_q, addr_b_q;
    logic [DATA_W-1:0] hold_a_q;

    logic accept;
    assign accept = (state_q == ST_IDLE) && start_i;

    // ---------------- page resolution ----------------
    logic [RW-1:0]     div_a, div_b, idx_a, idx_b;
    logic [ADDR_W-1:0] loc_a, loc_b;

    pgx_page_loc #(
        .ADDR_W(ADDR_W), .PAGE_LEN(PAGE_LEN), .MAX_PAGES(MAX_PAGES), .SEL_W(SEL_W)
    ) u_loc_a (
        .base_i(base_a_q), .pages_i(pages_a_q), .pick_i(pick_a_q),
        .div_o(div_a), .idx_o(idx_a), .addr_o(loc_a)
    );

    pgx_page_loc #(
        .ADDR_W(ADDR_W), .PAGE_LEN(PAGE_LEN), .MAX_PAGES(MAX_PAGES), .SEL_W(SEL_W)
    ) u_loc_b (
        .base_i(base_b_q), .pages_i(pages_b_q), .pick_i(pick_b_q),
        .div_o(div_b), .idx_o(idx_b), .addr_o(loc_b)
    );

    logic same_page;
    assign same_page = (loc_a == loc_b);

    // ---------------- word walk ----------------
    logic [WORD_W-1:0] word;
    logic              word_last;

    pgx_word_ctr #(.PAGE_LEN(PAGE_LEN)) u_word (
        .clk(clk), .rst_n(rst_n),
        .clr_i(state_q == ST_CALC),
        .inc_i(state_q == ST_WRB),
        .word_o(word), .last_o(word_last)
    );

    logic [ADDR_W-1:0] slot_a, slot_b;
    assign slot_a = addr_a_q + ADDR_W'(word);
    assign slot_b = addr_b_q + ADDR_W'(word);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_CALC : ST_IDLE;
            ST_CALC: state_d = same_page ? ST_FIN : ST_RDA;
            ST_RDA:  state_d = ST_RDB;
            ST_RDB:  state_d = ST_WRA;
            ST_WRA:  state_d = ST_WRB;
            ST_WRB:  state_d = word_last ? ST_FIN : ST_RDA;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- operand and data registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_a_q  <= '0;
            base_b_q  <= '0;
            pages_a_q <= '0;
            pages_b_q <= '0;
            pick_a_q  <= '0;
            pick_b_q  <= '0;
            addr_a_q  <= '0;
            addr_b_q  <= '0;
            hold_a_q  <= '0;
        end else begin
            if (accept) begin
                base_a_q  <= base_a_i;
                base_b_q  <= base_b_i;
                pages_a_q <= pages_a_i;
                pages_b_q <= pages_b_i;
                pick_a_q  <= pick_a_i;
                pick_b_q  <= pick_b_i;
            end
            if (state_q == ST_CALC) begin
                addr_a_q <= loc_a;
                addr_b_q <= loc_b;
            end
            // word of page A arrives the cycle after its read
            if (state_q == ST_RDB)
                hold_a_q <= mem_rdata_i;
        end
    end

    // ---------------- Moore outputs ----------------
    always_comb begin
        mem_en_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        busy_o      = 1'b1;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_CALC: ;
            ST_RDA: begin
                mem_en_o   = 1'b1;
                mem_addr_o = slot_a;
            end
            ST_RDB: begin
                mem_en_o   = 1'b1;
                mem_addr_o = slot_b;
            end
            ST_WRA: begin
                mem_en_o    = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = slot_a;
                mem_wdata_o = mem_rdata_i;
            end
            ST_WRB: begin
                mem_en_o    = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = slot_b;
                mem_wdata_o = hold_a_q;
            end
            ST_FIN:  done_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    // ---------------- assertions ----------------
    // R2
    page_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC) |-> ((idx_a < div_a) && (idx_b < div_b)));

    // R6
    calc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy_o && !mem_en_o));

    // R5
    write_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(mem_en_o));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(pick_a_q) && $stable(pick_b_q) &&
                                 $stable(base_a_q) && $stable(base_b_q)));

    // R9
    same_page_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CALC) && same_page) |=> (!mem_en_o && done_o));

endmodule

// File: tb/pgx_xover_tb_top.sv
`timescale 1ns/1ps
module pgx_xover_tb_top;

    localparam int MEMSZ = 1024;
    localparam int PL    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  base_a = '0, base_b = '0;
    logic [4:0]  pages_a = '0, pages_b = '0;
    logic [7:0]  pick_a = '0, pick_b = '0;
    logic        mem_en, mem_we, busy, done;
    logic [9:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    pgx_xover dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .base_a_i(base_a), .pages_a_i(pages_a), .pick_a_i(pick_a),
        .base_b_i(base_b), .pages_b_i(pages_b), .pick_b_i(pick_b),
        .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done)
    );

    // Behavioural single-port memory, one-cycle read latency
    logic [15:0] mem     [0:MEMSZ-1];
    logic [15:0] ref_mem [0:MEMSZ-1];

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end

    // Per-cycle expectation queue
    typedef struct packed {
        logic        busy;
        logic        done;
        logic        en;
        logic        we;
        logic [9:0]  addr;
        logic [15:0] wdata;
        logic [3:0]  tag;
    } exp_t;

    exp_t eq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   run = 0;
    bit   prev_idle = 1;
    bit   finished = 0;

    function automatic exp_t mk(bit b, bit d, bit e, bit w, int a, logic [15:0] wd, int t);
        exp_t x;
        x.busy = b; x.done = d; x.en = e; x.we = w;
        x.addr = 10'(a); x.wdata = wd; x.tag = 4'(t);
        return x;
    endfunction

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (run) begin
            exp_t e;
            bit   bad;
            if (eq.size() != 0) begin
                e = eq.pop_front();
                prev_idle = 0;
            end else begin
                e = mk(0, 0, 0, 0, 0, '0, 1); // R1: idle outputs
                prev_idle = 1;
            end
            bad = (busy !== e.busy) || (done !== e.done) || (mem_en !== e.en) || (mem_we !== e.we);
            if (e.en && (mem_addr !== e.addr)) bad = 1;
            if (e.en && e.we && (mem_wdata !== e.wdata)) bad = 1;
            n_cmp++;
            if (bad) begin
                n_bad++;
                $display("FAIL R%0d t=%0t got busy%b done%b en%b we%b addr=%0d wd=%h exp busy%b done%b en%b we%b addr=%0d wd=%h",
                         e.tag, $time, busy, done, mem_en, mem_we, mem_addr, mem_wdata,
                         e.busy, e.done, e.en, e.we, e.addr, e.wdata);
            end
        end
    end

    function automatic int eff_cnt(int c);
        if (c == 0) return 1;
        if (c > 16) return 16;
        return c;
    endfunction

    // Issue one start; expectations are pushed only if the block is idle at the sampling edge
    task automatic launch(int ba, int ca, int sa, int bb, int cb, int sb);
        @(negedge clk); #1;
        base_a = 10'(ba); pages_a = 5'(ca); pick_a = 8'(sa);
        base_b = 10'(bb); pages_b = 5'(cb); pick_b = 8'(sb);
        start = 1'b1;
        if (prev_idle && eq.size() == 0) begin
            int pa, pb;
            // R2: page = pick mod effective count, start = base + page*8, wrapped
            pa = (ba + (sa % eff_cnt(ca)) * PL) % MEMSZ;
            pb = (bb + (sb % eff_cnt(cb)) * PL) % MEMSZ;
            eq.push_back(mk(1, 0, 0, 0, 0, '0, 6)); // R6: address resolution cycle
            if (pa == pb) begin
                eq.push_back(mk(1, 1, 0, 0, 0, '0, 9)); // R9: no access, early done
            end else begin
                for (int k = 0; k < PL; k++) begin
                    int aa, ab;
                    logic [15:0] va, vb;
                    aa = (pa + k) % MEMSZ;
                    ab = (pb + k) % MEMSZ;
                    va = ref_mem[aa];
                    vb = ref_mem[ab];
                    // R4: read A, read B, write A, write B per word
                    eq.push_back(mk(1, 0, 1, 0, aa, '0, 4));
                    eq.push_back(mk(1, 0, 1, 0, ab, '0, 4));
                    eq.push_back(mk(1, 0, 1, 1, aa, vb, 5)); // R5: data read from B
                    eq.push_back(mk(1, 0, 1, 1, ab, va, 5));
                    ref_mem[aa] = vb;
                    ref_mem[ab] = va;
                end
                eq.push_back(mk(1, 1, 0, 0, 0, '0, 7)); // R7: single done pulse
            end
        end else begin
            // R8: start while busy; the remaining cycles must be unchanged
            foreach (eq[i]) eq[i].tag = 4'd8;
        end
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (eq.size() != 0 || !prev_idle) @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        for (int i = 0; i < MEMSZ; i++) begin
            mem[i]     = 16'(i * 40503 + 17);
            ref_mem[i] = 16'(i * 40503 + 17);
        end
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        run = 1;
        repeat (4) @(negedge clk); // R1: reset/idle state checked each cycle

        launch(0, 4, 2, 100, 3, 7);       // basic swap, picks above count
        wait_idle();
        launch(400, 16, 255, 600, 5, 200); // large picks
        wait_idle();
        launch(700, 0, 9, 800, 20, 17);   // zero count and oversize count (R2)
        wait_idle();
        launch(200, 2, 1, 208, 1, 9);     // same page address (R9)
        wait_idle();
        launch(1016, 2, 1, 500, 1, 0);    // address wrap past the top (R2)
        wait_idle();
        launch(300, 1, 0, 304, 1, 0);     // partially overlapping pages (R3)
        wait_idle();
        launch(40, 3, 5, 900, 4, 6);      // then a start mid-exchange (R8)
        repeat (10) @(negedge clk);
        launch(0, 1, 0, 8, 1, 0);
        wait_idle();
        launch(120, 2, 0, 140, 2, 1);     // start raised during the done cycle (R8)
        while (!(eq.size() == 1)) @(negedge clk);
        launch(0, 1, 0, 8, 1, 0);
        wait_idle();
        launch(64, 5, 3, 64, 5, 8);       // same pick after reduction (R9)
        wait_idle();
        repeat (3) @(negedge clk);

        // R3: final memory image matches the model word for word
        for (int i = 0; i < MEMSZ; i++) begin
            n_cmp++;
            if (mem[i] !== ref_mem[i]) begin
                n_bad++;
                $display("FAIL R3 word %0d got %h exp %h", i, mem[i], ref_mem[i]);
            end
        end
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired got hung exp completion");
            summary();
            $finish;
        end
    end

endmodule